// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block holds the eight status flags of an asynchronous serial port and decides, cycle by cycle, when each one sets and when it clears. The transmitter and receiver cores report what they did as single-cycle event pulses. A CPU reads and writes the flags through a simple register strobe interface. A block-transfer engine may also move data in and out of the port's data registers, and the block sees those transfers as strobes too. From these inputs the block keeps the flags up to date and tells the receive path when a finished character may be copied into the receive data register.

The error and buffer flags use a read-then-write-zero handshake. A flag clears only when software writes 0 to it after a read that returned it as 1, so a flag that sets between the read and the write is never lost. A hardware set that lands in the same cycle as a clear always wins. The shift registers, the baud generator and bit-level framing are outside this block.

Top module: `serial_status_flags`

## Requirements
- R1: After reset the status byte reads 0x84. The bit positions, MSB first, are: tx-empty (7), rx-full (6), overrun (5), framing error (4), parity error (3), tx-end (2), received multiprocessor bit (1), multiprocessor bit to send (0).
- R2: Bits 7 to 3 clear only when a CPU write puts 0 in a bit that an earlier CPU read returned as 1. A write of 1 leaves them unchanged, and so does a write of 0 that no such read came before.
- R3: Any CPU write disarms every pending clear. A second write of 0 does not clear a flag unless a new read came between the two writes.
- R4: Tx-empty sets while `tx_en` is 0 or on a `tx_load` pulse. It clears on an `xfer_tx_wr` strobe.
- R5: Tx-end sets while `tx_en` is 0, or on a `tx_last_bit` pulse while tx-empty is 1. A `tx_last_bit` pulse while tx-empty is 0 leaves it unchanged. Tx-end clears whenever tx-empty is cleared by the CPU or by `xfer_tx_wr`.
- R6: When a reception completes with `rx_en` high, no error and rx-full at 0, `rx_buf_load` is high in that cycle and rx-full sets. Rx-full clears on an `xfer_rx_rd` strobe.
- R7: When a reception completes while rx-full is 1, overrun sets, `rx_buf_load` stays low and rx-full stays 1.
- R8: A completed reception with `rx_stop_bit` at 0 sets the framing error flag and does not assert `rx_buf_load`.
- R9: With `parity_en` high, the parity error flag sets when the XOR of the data bits and `rx_parity_bit` differs from `parity_odd` (0 selects even, 1 selects odd). With `parity_en` low, parity never sets the flag.
- R10: While `rx_en` is 0, a `rx_done` pulse has no effect. No flag changes and `rx_buf_load` stays low.
- R11: Bit 1 takes `rx_mp_bit` on each accepted reception. CPU writes change neither bit 1 nor bit 2.
- R12: Bit 0 is a plain read/write bit that every CPU write loads from `cpu_wdata[0]`. It drives `tx_mp_bit`.
- R13: When a hardware set event and a clear (from the CPU or from a transfer strobe) hit the same flag in the same cycle, the flag ends up at 1.
- R14: `irq_txe` follows tx-empty, `irq_rxf` follows rx-full, and `irq_err` is the OR of overrun, framing error and parity error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_rd | input | 1 | CPU read strobe of the status byte |
| cpu_wr | input | 1 | CPU write strobe of the status byte |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Status byte |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| tx_load | input | 1 | Holding data moved into the transmit shifter |
| tx_last_bit | input | 1 | Last bit of a character is being sent |
| rx_done | input | 1 | A reception has completed |
| rx_data | input | DATA_W | Received data bits |
| rx_parity_bit | input | 1 | Received parity bit |
| rx_stop_bit | input | 1 | Sampled stop bit |
| rx_mp_bit | input | 1 | Received multiprocessor bit |
| parity_en | input | 1 | Parity checking enabled |
| parity_odd | input | 1 | 1 selects odd parity, 0 selects even |
| xfer_tx_wr | input | 1 | Transfer engine wrote the transmit data register |
| xfer_rx_rd | input | 1 | Transfer engine read the receive data register |
| rx_buf_load | output | 1 | Copy the received character into the receive data register |
| tx_mp_bit | output | 1 | Multiprocessor bit for the next character sent |
| irq_txe | output | 1 | Transmit-empty request |
| irq_rxf | output | 1 | Receive-full request |
| irq_err | output | 1 | Receive error request |

## Verification
The receive path gets a clean character, a character that arrives while the buffer is still full, one with a bad stop bit, and characters whose parity is right or wrong under even mode, under odd mode and with checking off. Together these show which error each pattern raises and whether the buffer load is suppressed. The clear handshake is run as a write with no read before it, a write of ones, a second write after a disarming write, and a proper read-then-write-zero, so a missing arm latch can be told apart from a missing disarm. The transmit flags are tried with the last-bit event both with and without tx-empty set. Same-cycle set and clear pairs are applied to confirm that the set wins.

// File: rtl/ssf_pkg.sv
package ssf_pkg;
  localparam int unsigned STAT_W  = 8;
  localparam int unsigned B_TXE   = 7;
  localparam int unsigned B_RXF   = 6;
  localparam int unsigned B_OVR   = 5;
  localparam int unsigned B_FRM   = 4;
  localparam int unsigned B_PAR   = 3;
  localparam int unsigned B_TXD   = 2;
  localparam int unsigned B_MPR   = 1;
  localparam int unsigned B_MPT   = 0;
  // bits B_TXE down to B_PAR use the read-then-write-zero clear
  localparam int unsigned N_CLR   = B_TXE - B_PAR + 1;
  localparam logic [STAT_W-1:0] STAT_RST = 8'h84;
  typedef logic [STAT_W-1:0] stat_t;
endpackage

// File: rtl/ssf_clear_arm.sv
module ssf_clear_arm #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd,
  input  logic         wr,
  input  logic [N-1:0] flags,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] clr
);
  logic [N-1:0] arm_q;
  logic [N-1:0] arm_d;
  logic         arm_en;

  assign arm_en = rd | wr;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_bit
      // a write disarms; a read arms every flag seen at 1
      always_comb begin
        if (wr) arm_d[i] = 1'b0;
        else    arm_d[i] = arm_q[i] | flags[i];
      end
      assign clr[i] = wr & arm_q[i] & ~wbits[i];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      arm_q <= '0;
    else if (arm_en) arm_q <= arm_d;
  end
endmodule

// File: rtl/ssf_tx_flags.sv
module ssf_tx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic tx_load,
  input  logic tx_last_bit,
  input  logic xfer_tx_wr,
  input  logic cpu_clr_txe,
  input  logic cpu_wr,
  input  logic cpu_wbit,
  output logic txe,
  output logic txd,
  output logic mpt
);
  logic txe_q, txe_d, txd_q, txd_d, mpt_q;
  logic txe_set, txd_set, txe_clr;

  always_comb begin
    txe_set = ~tx_en | tx_load;
    txd_set = ~tx_en | (tx_last_bit & txe_q);
    txe_clr = cpu_clr_txe | xfer_tx_wr;
    if (txe_set)      txe_d = 1'b1;
    else if (txe_clr) txe_d = 1'b0;
    else              txe_d = txe_q;
    if (txd_set)      txd_d = 1'b1;
    else if (txe_clr) txd_d = 1'b0;
    else              txd_d = txd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txe_q <= 1'b1;
      txd_q <= 1'b1;
    end else begin
      txe_q <= txe_d;
      txd_q <= txd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mpt_q <= 1'b0;
    else if (cpu_wr) mpt_q <= cpu_wbit;
  end

  assign txe = txe_q;
  assign txd = txd_q;
  assign mpt = mpt_q;
endmodule

// File: rtl/ssf_rx_flags.sv
module ssf_rx_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_parity_bit,
  input  logic              rx_stop_bit,
  input  logic              rx_mp_bit,
  input  logic              parity_en,
  input  logic              parity_odd,
  input  logic              xfer_rx_rd,
  input  logic [3:0]        cpu_clr,   // {rxf, ovr, frm, par}
  output logic              rxf,
  output logic [2:0]        err,       // {ovr, frm, par}
  output logic              mpr,
  output logic              buf_load
);
  localparam int N_ERR = 3;

  logic              accept, frame_bad, par_bad;
  logic              rxf_q, rxf_d, mpr_q;
  logic [N_ERR-1:0]  err_q, err_d, err_set, err_clr;

  always_comb begin
    accept    = rx_done & rx_en;
    frame_bad = ~rx_stop_bit;
    par_bad   = parity_en & ((^{rx_data, rx_parity_bit}) != parity_odd);
    buf_load  = accept & ~rxf_q & ~frame_bad & ~par_bad;
    err_set   = {accept & rxf_q, accept & frame_bad, accept & par_bad};
    err_clr   = cpu_clr[2:0];
    if (buf_load)                    rxf_d = 1'b1;
    else if (cpu_clr[3] | xfer_rx_rd) rxf_d = 1'b0;
    else                             rxf_d = rxf_q;
  end

  genvar k;
  generate
    for (k = 0; k < N_ERR; k++) begin : g_err
      always_comb begin
        if (err_set[k])      err_d[k] = 1'b1;
        else if (err_clr[k]) err_d[k] = 1'b0;
        else                 err_d[k] = err_q[k];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxf_q <= 1'b0;
      err_q <= '0;
    end else begin
      rxf_q <= rxf_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mpr_q <= 1'b0;
    else if (accept) mpr_q <= rx_mp_bit;
  end

  assign rxf = rxf_q;
  assign err = err_q;
  assign mpr = mpr_q;
endmodule

// File: rtl/serial_status_flags.sv
module serial_status_flags
  import ssf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              tx_load,
  input  logic              tx_last_bit,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_parity_bit,
  input  logic              rx_stop_bit,
  input  logic              rx_mp_bit,
  input  logic              parity_en,
  input  logic              parity_odd,
  input  logic              xfer_tx_wr,
  input  logic              xfer_rx_rd,
  output logic              rx_buf_load,
  output logic              tx_mp_bit,
  output logic              irq_txe,
  output logic              irq_rxf,
  output logic              irq_err
);
  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  stat_t            stat;
  logic [N_CLR-1:0] clr;
  logic             txe, txd, mpt, rxf, mpr;
  logic [2:0]       err;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  ssf_clear_arm #(.N(N_CLR)) u_arm (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .rd    (cpu_rd),
    .wr    (cpu_wr),
    .flags (stat[B_TXE:B_PAR]),
    .wbits (cpu_wdata[B_TXE:B_PAR]),
    .clr   (clr)
  );

  ssf_tx_flags u_tx (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .tx_en       (tx_en),
    .tx_load     (tx_load),
    .tx_last_bit (tx_last_bit),
    .xfer_tx_wr  (xfer_tx_wr),
    .cpu_clr_txe (clr[B_TXE-B_PAR]),
    .cpu_wr      (cpu_wr),
    .cpu_wbit    (cpu_wdata[B_MPT]),
    .txe         (txe),
    .txd         (txd),
    .mpt         (mpt)
  );

  ssf_rx_flags #(.DATA_W(DATA_W)) u_rx (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .rx_en         (rx_en),
    .rx_done       (rx_done),
    .rx_data       (rx_data),
    .rx_parity_bit (rx_parity_bit),
    .rx_stop_bit   (rx_stop_bit),
    .rx_mp_bit     (rx_mp_bit),
    .parity_en     (parity_en),
    .parity_odd    (parity_odd),
    .xfer_rx_rd    (xfer_rx_rd),
    .cpu_clr       (clr[B_RXF-B_PAR:0]),
    .rxf           (rxf),
    .err           (err),
    .mpr           (mpr),
    .buf_load      (rx_buf_load)
  );

  always_comb begin
    stat        = '0;
    stat[B_TXE] = txe;
    stat[B_RXF] = rxf;
    stat[B_OVR] = err[2];
    stat[B_FRM] = err[1];
    stat[B_PAR] = err[0];
    stat[B_TXD] = txd;
    stat[B_MPR] = mpr;
    stat[B_MPT] = mpt;
  end

  assign cpu_rdata = stat;
  assign tx_mp_bit = mpt;
  assign irq_txe   = txe;
  assign irq_rxf   = rxf;
  assign irq_err   = |err;
endmodule

// File: rtl/ssf_checker.sv
module ssf_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_wr,
  input logic       cpu_wd0,
  input logic [7:0] st,
  input logic       tx_en,
  input logic       tx_load,
  input logic       rx_en,
  input logic       rx_done,
  input logic       rx_stop_bit,
  input logic       rx_mp_bit,
  input logic       xfer_rx_rd,
  input logic       rx_buf_load
);
  a_r4_txen_low_sets_txe: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> st[7]);
  a_r13_load_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> st[7]);
  a_r5_tend_needs_txe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st[2]) |-> ($past(!tx_en) || $past(st[7])));
  a_r6_load_sets_rxf: assert property (@(posedge clk) disable iff (!rst_n)
    rx_buf_load |=> st[6]);
  a_r7_no_load_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_en && st[6]) |-> !rx_buf_load);
  a_r7_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_en && st[6]) |=> (st[5] && st[6]));
  a_r8_frame_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_en && !rx_stop_bit) |=> st[4]);
  a_r10_disabled_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> !rx_buf_load);
  a_r11_mpb_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_en) |=> (st[1] == $past(rx_mp_bit)));
  a_r12_mpbt_written: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |=> (st[0] == $past(cpu_wd0)));
  a_r2_rxf_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_wr && !xfer_rx_rd && st[6]) |=> st[6]);
endmodule

bind serial_status_flags ssf_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .cpu_wr      (cpu_wr),
  .cpu_wd0     (cpu_wdata[0]),
  .st          (cpu_rdata),
  .tx_en       (tx_en),
  .tx_load     (tx_load),
  .rx_en       (rx_en),
  .rx_done     (rx_done),
  .rx_stop_bit (rx_stop_bit),
  .rx_mp_bit   (rx_mp_bit),
  .xfer_rx_rd  (xfer_rx_rd),
  .rx_buf_load (rx_buf_load)
);

// File: tb/sim_serial_status_flags.sv
`timescale 1ns/1ps
module sim_serial_status_flags;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_rd = 0, cpu_wr = 0;
  logic [7:0] cpu_wdata = 0;
  logic [7:0] cpu_rdata;
  logic       tx_en = 1, rx_en = 1, tx_load = 0, tx_last_bit = 0;
  logic       rx_done = 0, rx_parity_bit = 0, rx_stop_bit = 1, rx_mp_bit = 0;
  logic [7:0] rx_data = 0;
  logic       parity_en = 0, parity_odd = 0, xfer_tx_wr = 0, xfer_rx_rd = 0;
  logic       rx_buf_load, tx_mp_bit, irq_txe, irq_rxf, irq_err;
  int         checks = 0, fails = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  serial_status_flags #(.DATA_W(8)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_bits(input logic [7:0] mask, input logic [7:0] exp, input string tag);
    chk((cpu_rdata & mask) == exp, tag, cpu_rdata & mask, exp);
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic rd();
    cpu_rd = 1; cyc(); cpu_rd = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    cpu_wr = 1; cpu_wdata = d; cyc(); cpu_wr = 0;
  endtask

  task automatic rx(input logic [7:0] d, input logic p, input logic s,
                    input logic m, output logic ld);
    rx_done = 1; rx_data = d; rx_parity_bit = p; rx_stop_bit = s; rx_mp_bit = m;
    #1 ld = rx_buf_load;
    @(negedge clk); rx_done = 0; rx_stop_bit = 1;
  endtask

  task automatic t_reset();
    chk(cpu_rdata == 8'h84, "R1 reset value", cpu_rdata, 8'h84);
    chk(irq_txe && !irq_rxf && !irq_err, "R14 reset requests",
        {5'b0, irq_txe, irq_rxf, irq_err}, 8'h04);
  endtask

  task automatic t_mpbt();
    wr(8'h01);
    chk(cpu_rdata == 8'h85, "R2 R11 R12 write without read", cpu_rdata, 8'h85);
    chk(tx_mp_bit == 1'b1, "R12 tx_mp_bit", {7'b0, tx_mp_bit}, 8'h01);
    wr(8'h00);
    chk(cpu_rdata == 8'h84, "R12 write 0", cpu_rdata, 8'h84);
  endtask

  task automatic t_clear_handshake();
    rd(); wr(8'hFF);
    chk(cpu_rdata == 8'h85, "R2 write ones", cpu_rdata, 8'h85);
    wr(8'h00);
    chk(cpu_rdata == 8'h84, "R3 disarmed by write", cpu_rdata, 8'h84);
    rd(); wr(8'h7F);
    chk(cpu_rdata == 8'h01, "R2 R5 armed clear", cpu_rdata, 8'h01);
    wr(8'h00);
    chk(irq_txe == 1'b0, "R14 irq_txe low", {7'b0, irq_txe}, 8'h00);
  endtask

  task automatic t_tx();
    tx_last_bit = 1; cyc(); tx_last_bit = 0;
    chk(cpu_rdata == 8'h00, "R5 last bit without txe", cpu_rdata, 8'h00);
    tx_load = 1; cyc(); tx_load = 0;
    chk(cpu_rdata == 8'h80, "R4 load sets txe", cpu_rdata, 8'h80);
    tx_last_bit = 1; cyc(); tx_last_bit = 0;
    chk(cpu_rdata == 8'h84, "R5 last bit sets tend", cpu_rdata, 8'h84);
    xfer_tx_wr = 1; cyc(); xfer_tx_wr = 0;
    chk(cpu_rdata == 8'h00, "R4 R5 transfer write clears", cpu_rdata, 8'h00);
    tx_en = 0; cyc(); tx_en = 1;
    chk(cpu_rdata == 8'h84, "R4 R5 tx disabled", cpu_rdata, 8'h84);
    rd();
    cpu_wr = 1; cpu_wdata = 8'h00; tx_load = 1; cyc(); cpu_wr = 0; tx_load = 0;
    chk(cpu_rdata == 8'h80, "R13 set beats cpu clear", cpu_rdata, 8'h80);
  endtask

  task automatic t_rx_main();
    logic ld;
    rx(8'hA5, 0, 1, 1, ld);
    chk(ld == 1, "R6 load on clean rx", {7'b0, ld}, 8'h01);
    chk_bits(8'h7A, 8'h42, "R6 R11 rxf and mpb");
    chk(irq_rxf == 1, "R14 irq_rxf", {7'b0, irq_rxf}, 8'h01);
    rx(8'h11, 0, 1, 0, ld);
    chk(ld == 0, "R7 no load on overrun", {7'b0, ld}, 8'h00);
    chk_bits(8'h7A, 8'h60, "R7 overrun flags");
    chk(irq_err == 1, "R14 irq_err", {7'b0, irq_err}, 8'h01);
    xfer_rx_rd = 1; cyc(); xfer_rx_rd = 0;
    chk_bits(8'h40, 8'h00, "R6 transfer read clears");
    rd(); wr(8'h00);
    chk_bits(8'h78, 8'h00, "R2 overrun cleared");
    rx(8'h55, 0, 0, 0, ld);
    chk(ld == 0, "R8 no load on framing", {7'b0, ld}, 8'h00);
    chk_bits(8'h78, 8'h10, "R8 framing flag");
    rd(); wr(8'h00);
  endtask

  task automatic t_parity();
    logic ld;
    parity_en = 1; parity_odd = 0;
    rx(8'h01, 0, 1, 0, ld);
    chk(ld == 0 && (cpu_rdata & 8'h78) == 8'h08, "R9 even bad", cpu_rdata, 8'h08);
    rd(); wr(8'h00);
    rx(8'h03, 0, 1, 0, ld);
    chk(ld == 1 && (cpu_rdata & 8'h78) == 8'h40, "R9 even good", cpu_rdata, 8'h40);
    xfer_rx_rd = 1; cyc(); xfer_rx_rd = 0;
    parity_odd = 1;
    rx(8'h03, 1, 1, 0, ld);
    chk(ld == 1 && (cpu_rdata & 8'h78) == 8'h40, "R9 odd good", cpu_rdata, 8'h40);
    xfer_rx_rd = 1; cyc(); xfer_rx_rd = 0;
    rx(8'h03, 0, 1, 0, ld);
    chk(ld == 0 && (cpu_rdata & 8'h78) == 8'h08, "R9 odd bad", cpu_rdata, 8'h08);
    rd(); wr(8'h00);
    parity_en = 0;
    rx(8'h01, 0, 1, 0, ld);
    chk(ld == 1 && (cpu_rdata & 8'h78) == 8'h40, "R9 parity off", cpu_rdata, 8'h40);
    xfer_rx_rd = 1; cyc(); xfer_rx_rd = 0;
  endtask

  task automatic t_rx_off_and_mpb();
    logic ld;
    rx_en = 0;
    rx(8'h00, 0, 0, 1, ld);
    rx_en = 1;
    chk(ld == 0, "R10 no load when disabled", {7'b0, ld}, 8'h00);
    chk_bits(8'h7A, 8'h00, "R10 flags unchanged");
    rx(8'h00, 0, 1, 1, ld);
    chk_bits(8'h02, 8'h02, "R11 mpb from rx");
    wr(8'h00);
    chk_bits(8'h42, 8'h42, "R11 R2 write leaves mpb and rxf");
    xfer_rx_rd = 1; cyc(); xfer_rx_rd = 0;
    xfer_rx_rd = 1; rx(8'h00, 0, 1, 0, ld); xfer_rx_rd = 0;
    chk_bits(8'h40, 8'h40, "R13 rx set beats transfer read");
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_mpbt();
    t_clear_handshake();
    t_tx();
    t_rx_main();
    t_parity();
    t_rx_off_and_mpb();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule